// File: doc/BRIEF.md
# Prescaled Down Timer

A 32-bit down-counting timer for one timer or watchdog slot of one processor. Software reaches it through a small register port: a byte offset, a write strobe, write data and combinational read data. The port holds a reload value, the live count, a control word (run enable, periodic mode and an 8-bit clock divider) and a sticky expiry flag. While the timer is running, the count drops by one every (divider + 1) clock cycles. When the count reaches zero, the expiry flag is set. In periodic mode the count then starts again from the reload value. In single-shot mode it stays at zero.

The interrupt line gives a one-cycle pulse only when the expiry flag goes from clear to set. An expiry that happens while the flag is still set therefore raises no new request. Software clears the flag by writing a one to bit 0 of the status word. One instance is placed per slot, and the interrupt controller and any watchdog reset logic sit outside the block.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset, all four registers read as zero and irq_o is low.
- R2: Registers sit at byte offsets 0x0 (reload value), 0x4 (live count), 0x8 (control) and 0xC (status). Every other offset, unaligned ones included, reads as zero, and writes to it change nothing. Control reads back only bit 0 (run), bit 1 (periodic) and bits 15:8 (divider). All other control bits read zero.
- R3: A write to 0x0 stores the value as the reload value and also copies it into the live count. A write to 0x4 changes the live count only.
- R4: While run is set and the count is nonzero, the count drops by one every (divider + 1) cycles. While run is clear, the count holds.
- R5: In single-shot mode (bit 1 clear), the step from 1 to 0 sets the status flag. The count then stays at zero and counting stops.
- R6: In periodic mode (bit 1 set), the step that reaches zero sets the status flag and reloads the count from the reload value in the same cycle.
- R7: A control write that sets run while run was clear, the count is zero and the written periodic bit is one first copies the reload value into the count. In single-shot mode the same write leaves a zero count at zero.
- R8: The live count reads as zero while run is clear.
- R9: The status flag (bit 0 at 0xC) stays set until a write to 0xC with bit 0 at one. Writing bit 0 as zero has no effect.
- R10: irq_o is high for exactly one cycle, in the first cycle the status flag reads one. An expiry while the flag is already set gives no pulse.
- R11: The divider phase restarts from zero on any write to 0x0 or 0x4, and on a write that sets run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | One-cycle interrupt request on a new expiry |

## Verification
The count is sampled in every cycle across a single-shot run with a divider of zero. This separates the immediate-decrement path from the stop-at-zero path. A periodic run with a divider of two is sampled on both sides of a divider boundary and across two reloads. One of those reloads comes after the flag is cleared and one while the flag is still set, which separates edge-triggered interrupts from level-triggered ones. A reload-value write made part way through a divider period shows whether the phase restarts. Separate enable writes with a zero count, in periodic and in single-shot mode, isolate the enable-time reload. Writes to undefined and unaligned offsets, followed by register reads, show that they are ignored.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned RUN_BIT    = 0;
  localparam int unsigned PERIOD_BIT = 1;
  localparam int unsigned DIV_LSB    = 8;

  // register index = addr[3:2]
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STAT   = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 4;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              expire_i,
  output logic              we_reload_o,
  output logic              we_count_o,
  output logic              run_rise_o,
  output logic              period_new_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              run_o,
  output logic              period_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              status_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned CTRL_W = DIV_LSB + DIV_W;

  logic                 addr_ok;
  logic [NUM_REGS-1:0]  hit;
  logic [NUM_REGS-1:0]  we;
  logic [DATA_W-1:0]    reload_q;
  logic                 run_q, period_q, status_q, status_d, irq_q;
  logic [DIV_W-1:0]     div_q;
  logic [DATA_W-1:0]    ctrl_rd;

  assign addr_ok = (addr_i[1:0] == 2'b00) && ((addr_i >> 4) == '0);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign hit[g] = addr_ok && (addr_i[3:2] == 2'(g));
    assign we[g]  = hit[g] && wr_en_i;
  end

  assign we_reload_o  = we[SEL_RELOAD];
  assign we_count_o   = we[SEL_COUNT];
  assign period_new_o = wr_data_i[PERIOD_BIT];
  assign run_rise_o   = we[SEL_CTRL] && wr_data_i[RUN_BIT] && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      run_q    <= 1'b0;
      period_q <= 1'b0;
      div_q    <= '0;
    end else begin
      if (we[SEL_RELOAD]) reload_q <= wr_data_i;
      if (we[SEL_CTRL]) begin
        run_q    <= wr_data_i[RUN_BIT];
        period_q <= wr_data_i[PERIOD_BIT];
        div_q    <= wr_data_i[DIV_LSB +: DIV_W];
      end
    end
  end

  // set from expiry dominates a same-cycle clear
  always_comb begin
    status_d = status_q;
    if (we[SEL_STAT] && wr_data_i[0]) status_d = 1'b0;
    if (expire_i)                     status_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= status_d && !status_q;
    end
  end

  always_comb begin
    ctrl_rd                    = '0;
    ctrl_rd[RUN_BIT]           = run_q;
    ctrl_rd[PERIOD_BIT]        = period_q;
    ctrl_rd[DIV_LSB +: DIV_W]  = div_q;
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_ok) begin
      unique case (reg_sel_e'(addr_i[3:2]))
        SEL_RELOAD: rd_data_o = reload_q;
        SEL_COUNT:  rd_data_o = run_q ? count_i : '0;
        SEL_CTRL:   rd_data_o = ctrl_rd;
        SEL_STAT:   rd_data_o = {{(DATA_W-1){1'b0}}, status_q};
        default:    rd_data_o = '0;
      endcase
    end
  end

  assign reload_o = reload_q;
  assign run_o    = run_q;
  assign period_o = period_q;
  assign div_o    = div_q;
  assign status_o = status_q;
  assign irq_o    = irq_q;

  if (DATA_W < CTRL_W) begin : g_bad_w
    initial $error("data width too small for control word");
  end
endmodule

// File: rtl/ptmr_divider.sv
module ptmr_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             step_o
);
  logic [DIV_W-1:0] phase_q;
  logic             wrap;

  // >= keeps a lowered divider from stalling the phase
  assign wrap   = (phase_q >= div_i);
  assign step_o = run_i && !restart_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (run_i)     phase_q <= wrap ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_reload_i,
  input  logic              we_count_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              run_rise_i,
  input  logic              period_new_i,
  input  logic              period_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] count_q, count_d;

  always_comb begin
    count_d  = count_q;
    expire_o = 1'b0;
    if (we_reload_i || we_count_i) begin
      count_d = wr_data_i;
    end else if (run_rise_i && (count_q == '0) && period_new_i) begin
      count_d = reload_i;
    end else if (step_i) begin
      if (count_q == ONE) begin
        expire_o = 1'b1;
        count_d  = period_i ? reload_i : '0;
      end else begin
        count_d = count_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic              we_reload, we_count, run_rise, period_new;
  logic [DATA_W-1:0] reload_q, count_q;
  logic              run_q, period_q, status_q;
  logic [DIV_W-1:0]  div_q;
  logic              expire, step, running, restart;

  assign running = run_q && (count_q != '0);
  assign restart = we_reload || we_count || run_rise;

  ptmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .count_i      (count_q),
    .expire_i     (expire),
    .we_reload_o  (we_reload),
    .we_count_o   (we_count),
    .run_rise_o   (run_rise),
    .period_new_o (period_new),
    .reload_o     (reload_q),
    .run_o        (run_q),
    .period_o     (period_q),
    .div_o        (div_q),
    .status_o     (status_q),
    .rd_data_o    (rd_data_o),
    .irq_o        (irq_o)
  );

  ptmr_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (running),
    .restart_i (restart),
    .div_i     (div_q),
    .step_o    (step)
  );

  ptmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_reload_i  (we_reload),
    .we_count_i   (we_count),
    .wr_data_i    (wr_data_i),
    .run_rise_i   (run_rise),
    .period_new_i (period_new),
    .period_i     (period_q),
    .reload_i     (reload_q),
    .step_i       (step),
    .count_o      (count_q),
    .expire_o     (expire)
  );
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              irq_o,
  input logic              status_q,
  input logic              run_q,
  input logic              period_q,
  input logic [DATA_W-1:0] count_q,
  input logic [DATA_W-1:0] reload_q
);
  logic wr_reload, wr_stat_clr;
  assign wr_reload   = wr_en_i && (addr_i == ADDR_W'(5'h00));
  assign wr_stat_clr = wr_en_i && (addr_i == ADDR_W'(5'h0C)) && wr_data_i[0];

  AST_RELOAD_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_reload |=> (count_q == $past(wr_data_i)) && (reload_q == $past(wr_data_i))); // R3

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_en_i) |=> $stable(count_q)); // R4

  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && (count_q > DATA_W'(1)) && !wr_en_i)
      |=> (count_q == $past(count_q)) || (count_q == $past(count_q) - DATA_W'(1))); // R4

  AST_ONESHOT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !period_q && (count_q == '0) && !wr_en_i) |=> (count_q == '0)); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !wr_stat_clr) |=> status_q); // R9

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R10

  AST_IRQ_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_q && !$past(status_q))); // R10
endmodule

bind prescaled_down_timer ptmr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .status_q  (status_q),
  .run_q     (run_q),
  .period_q  (period_q),
  .count_q   (count_q),
  .reload_q  (reload_q)
);

// File: tb/prescaled_down_timer_bench.sv
module prescaled_down_timer_bench;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [4:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] data;
    logic        irq;
    string       tag;
  } item_t;

  item_t sb_q[$];

  prescaled_down_timer u_prescaled_down_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // all tasks start and end on a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [4:0] a, input logic [31:0] exp,
                     input logic exp_irq, input string tag);
    item_t it;
    addr = a;
    it.data = exp; it.irq = exp_irq; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (rd_data !== it.data || irq !== it.irq) begin
          n_fail++;
          $display("FAIL %s: got rd_data=%h irq=%b, expected rd_data=%h irq=%b",
                   it.tag, rd_data, irq, it.data, it.irq);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(5'h00, 32'h0, 1'b0, "R1 reload");
    chk(5'h04, 32'h0, 1'b0, "R1 count");
    chk(5'h08, 32'h0, 1'b0, "R1 ctrl");
    chk(5'h0C, 32'h0, 1'b0, "R1 status");

    // R3 / R8: reload write copies count, count hidden while stopped
    wr(5'h00, 32'd5);
    chk(5'h00, 32'd5, 1'b0, "R3 reload stored");
    chk(5'h04, 32'd0, 1'b0, "R8 count reads zero when stopped");

    // R4 / R5: single-shot, divider 0
    wr(5'h08, 32'h0000_0001);
    chk(5'h04, 32'd5, 1'b0, "R3 count copied");
    chk(5'h04, 32'd4, 1'b0, "R4 div0 step");
    chk(5'h04, 32'd3, 1'b0, "R4 div0 step");
    chk(5'h04, 32'd2, 1'b0, "R4 div0 step");
    chk(5'h04, 32'd1, 1'b0, "R4 div0 step");
    chk(5'h0C, 32'd1, 1'b1, "R5 R10 expiry sets status and pulses");
    chk(5'h04, 32'd0, 1'b0, "R5 stays at zero, R10 pulse ends");
    idle(2);
    chk(5'h04, 32'd0, 1'b0, "R5 stopped");

    // R9 sticky flag
    wr(5'h0C, 32'h0);
    chk(5'h0C, 32'd1, 1'b0, "R9 zero write keeps flag");
    wr(5'h0C, 32'h1);
    chk(5'h0C, 32'd0, 1'b0, "R9 one write clears flag");

    // R6 / R10: periodic, divider 2, reload 3
    wr(5'h08, 32'h0);
    wr(5'h00, 32'd3);
    wr(5'h08, 32'h0000_0203);
    chk(5'h04, 32'd3, 1'b0, "R4 div2 k0");       // k0 -> k1
    idle(1);                                     // k2
    chk(5'h04, 32'd3, 1'b0, "R4 div2 before boundary");
    chk(5'h04, 32'd2, 1'b0, "R4 div2 at boundary"); // k3 -> k4
    idle(5);                                     // k9
    chk(5'h0C, 32'd1, 1'b1, "R6 R10 periodic expiry");
    chk(5'h04, 32'd3, 1'b0, "R6 count reloaded"); // k10 -> k11
    wr(5'h0C, 32'h1);                            // clear at edge 12
    idle(6);                                     // k18
    chk(5'h0C, 32'd1, 1'b1, "R10 new pulse after clear"); // -> k19
    idle(8);                                     // k27
    chk(5'h0C, 32'd1, 1'b0, "R10 no pulse while flag set");

    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
    chk(5'h0C, 32'd0, 1'b0, "R9 cleared");

    // R7 enable with zero count
    wr(5'h00, 32'd4);
    wr(5'h04, 32'd0);
    chk(5'h00, 32'd4, 1'b0, "R3 count write keeps reload");
    wr(5'h08, 32'h0000_0003);
    chk(5'h04, 32'd4, 1'b0, "R7 periodic enable loads reload");
    wr(5'h08, 32'h0);
    chk(5'h04, 32'd0, 1'b0, "R8 stopped count reads zero");
    wr(5'h04, 32'd0);
    wr(5'h08, 32'h0000_0001);
    idle(3);
    chk(5'h04, 32'd0, 1'b0, "R7 single-shot enable keeps zero");
    chk(5'h0C, 32'd0, 1'b0, "R7 no expiry from zero count");
    wr(5'h08, 32'h0);

    // R11: reload write part way through a divider period
    wr(5'h00, 32'd10);
    wr(5'h08, 32'h0000_0301);
    idle(2);                                     // phase 2
    wr(5'h00, 32'd7);
    chk(5'h04, 32'd7, 1'b0, "R11 written count");
    idle(2);
    chk(5'h04, 32'd7, 1'b0, "R11 phase restarted");
    chk(5'h04, 32'd6, 1'b0, "R11 step after full period");
    wr(5'h08, 32'h0);

    // R2 decode
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h01, 32'hAAAA_AAAA);
    chk(5'h00, 32'd7, 1'b0, "R2 stray writes ignored reload");
    chk(5'h08, 32'h0, 1'b0, "R2 stray writes ignored ctrl");
    chk(5'h10, 32'h0, 1'b0, "R2 undefined offset reads zero");
    chk(5'h02, 32'h0, 1'b0, "R2 unaligned offset reads zero");
    wr(5'h08, 32'hFFFF_FFFC);
    chk(5'h08, 32'h0000_FF00, 1'b0, "R2 control field readback");

    @(negedge clk);
    #(CLK_P/2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule